// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is the device end of a three-wire serial memory link: chip select, serial clock, data in, and a data out that can be released to high impedance. It stores 64 words of 16 bits in registers. A controller selects the device, clocks in a start bit, a 2-bit opcode and a 6-bit address, and then either clocks data out of it or clocks a 16-bit word into it. A fast system clock samples all three serial inputs through synchronizers. Every serial action happens on a detected rising edge of the serial clock.

A read drives one zero and then the addressed word, MSB first. If the controller keeps the device selected and keeps clocking, the next words follow with no zero in between. The address counts up and wraps from 63 to 0. A write is only armed by the serial transfer. Dropping chip select starts a self-timed store of `PROG_CYCLES` system clocks. While that store runs, reselecting the device shows busy (0) on data out, and afterwards it shows ready (1). Writes must first be enabled with a control command, and they are disabled after reset.

The control FSM has eight states:
- `ST_IDLE`: deselected.
- `ST_HUNT`: waiting for the start bit.
- `ST_CMD`: shifting in the opcode and address.
- `ST_DATA`: shifting in the write data.
- `ST_READ`: streaming words out.
- `ST_ARMED`: write complete, waiting for deselect.
- `ST_DONE`: command finished, waiting for deselect.
- `ST_POLL`: status shown on data out.

Its transitions are:
- Any state goes to IDLE when chip select is low.
- IDLE goes to POLL on select if a store is running or its status is still pending, and to HUNT otherwise.
- HUNT goes to CMD on a 1.
- CMD goes to READ, DATA or DONE after the 8th bit, chosen by the opcode.
- DATA goes to ARMED after the 16th bit.
- POLL goes to CMD on a 1 once the device is ready.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, data out is released (`dout_oe_o` low), writes are disabled and every stored word reads as 0.
- R2: Data in is sampled on serial clock rising edges. The start bit is the first 1 seen after chip select rises, so leading zeros are skipped. Two opcode bits follow it (10 = read, 01 = write, 00 = control), then 6 address bits, MSB first.
- R3: On the rising edge that samples the last address bit of a read, data out is driven to a single 0. The following rising edges present the addressed word MSB first.
- R4: While chip select stays high and clocking continues, the next address's word follows directly with no extra zero.
- R5: The sequential address after 63 is 0.
- R6: A write carries 16 data bits MSB first. The store starts when chip select falls and completes `PROG_CYCLES` system clocks later. It replaces the old word directly, with no erase required first.
- R7: With chip select high while a store runs, data out is driven to 0. Once the store finishes, it is driven to 1.
- R8: Control address bits 11xxxx enable writes and 00xxxx disable them. A write while disabled changes no word and starts no busy status.
- R9: Dropping chip select releases data out at once and discards any unfinished command, so a write cut short stores nothing.
- R10: While a store runs, serial commands are ignored and data out stays at busy.
- R11: After ready is shown, a start bit clocked in the same selection begins a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock |
| din_i | input | 1 | Serial data in |
| dout_o | output | 1 | Serial data out value |
| dout_oe_o | output | 1 | Data out drive enable; low means high impedance |

## Verification
A serial clock rise is seen through two synchronizer stages and an edge detector. The output register therefore updates within three system clocks of the pin edge. The bench holds each serial clock phase for ten system clocks and samples data out at the end of the high phase, well clear of that window.

A store begins about three clocks after chip select falls and lasts `PROG_CYCLES`. The bench checks busy ten clocks after reselecting, then polls for ready within a bounded window. Read words are gathered bit by bit and queued, and a monitor compares them in order against a model updated only when a write is allowed to take effect.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_CMD,
        ST_DATA,
        ST_READ,
        ST_ARMED,
        ST_DONE,
        ST_POLL
    } mw_state_e;

    localparam logic [1:0] OP_CTRL  = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;

    localparam logic [1:0] CTL_ENABLE  = 2'b11;
    localparam logic [1:0] CTL_DISABLE = 2'b00;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/mw_array.sv
module mw_array #(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              busy_o
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int TW    = $clog2(PROG_CYCLES + 1);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [TW-1:0]     timer_q;
    logic              busy_q;
    logic [ADDR_W-1:0] wa_q;
    logic [DATA_W-1:0] wd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            timer_q <= '0;
            wa_q    <= '0;
            wd_q    <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (start_i && !busy_q) begin
            busy_q  <= 1'b1;
            timer_q <= TW'(PROG_CYCLES - 1);
            wa_q    <= addr_i;
            wd_q    <= data_i;
        end else if (busy_q) begin
            if (timer_q == '0) begin
                mem_q[wa_q] <= wd_q;
                busy_q      <= 1'b0;
            end else begin
                timer_q <= timer_q - TW'(1);
            end
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];
    assign busy_o    = busy_q;

    // R6
    start_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_q);

    // R10
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !start_i);

endmodule

// File: rtl/mw_fsm.sv
module mw_fsm
    import mw_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              sk_rise_i,
    input  logic              di_i,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              prog_start_o,
    output logic [ADDR_W-1:0] prog_addr_o,
    output logic [DATA_W-1:0] prog_data_o,
    output logic              dout_o,
    output logic              dout_oe_o
);

    localparam int CMD_W = ADDR_W + 2;
    localparam int MAXW  = (DATA_W > CMD_W) ? DATA_W : CMD_W;
    localparam int CNT_W = $clog2(MAXW);

    mw_state_e         state_q, state_d;
    logic [CMD_W-2:0]  cmd_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] out_sh_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              dout_q, dout_oe_q, wen_q, stat_q, prog_start_q;

    logic [CMD_W-1:0]  cmd_next;
    logic [1:0]        op_next, ctl_next;
    logic              last_cmd, last_data;

    assign cmd_next  = {cmd_q, di_i};
    assign op_next   = cmd_next[CMD_W-1 -: 2];
    assign ctl_next  = cmd_next[ADDR_W-1 -: 2];
    assign last_cmd  = (cnt_q == CNT_W'(CMD_W - 1));
    assign last_data = (cnt_q == CNT_W'(DATA_W - 1));

    always_comb begin
        state_d = state_q;
        if (!cs_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = (busy_i || stat_q) ? ST_POLL : ST_HUNT;
                ST_HUNT:  if (sk_rise_i && di_i) state_d = ST_CMD;
                ST_CMD: begin
                    if (sk_rise_i && last_cmd) begin
                        case (op_next)
                            OP_READ:  state_d = ST_READ;
                            OP_WRITE: state_d = ST_DATA;
                            default:  state_d = ST_DONE;
                        endcase
                    end
                end
                ST_DATA:  if (sk_rise_i && last_data) state_d = ST_ARMED;
                ST_READ, ST_ARMED, ST_DONE: state_d = state_q;
                ST_POLL:  if (sk_rise_i && di_i && !busy_i) state_d = ST_CMD;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q        <= '0;
            data_q       <= '0;
            out_sh_q     <= '0;
            addr_q       <= '0;
            cnt_q        <= '0;
            dout_q       <= 1'b0;
            dout_oe_q    <= 1'b0;
            wen_q        <= 1'b0;
            stat_q       <= 1'b0;
            prog_start_q <= 1'b0;
        end else begin
            prog_start_q <= 1'b0;
            if (!cs_i) begin
                dout_oe_q <= 1'b0;
                dout_q    <= 1'b0;
                cnt_q     <= '0;
                if (state_q == ST_ARMED && wen_q) begin
                    prog_start_q <= 1'b1;
                    stat_q       <= 1'b1;
                end
                if (state_q == ST_POLL && !busy_i) stat_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_HUNT: begin
                        cnt_q <= '0;
                        cmd_q <= '0;
                    end
                    ST_CMD: if (sk_rise_i) begin
                        cmd_q <= cmd_next[CMD_W-2:0];
                        if (last_cmd) begin
                            cnt_q  <= '0;
                            addr_q <= cmd_next[ADDR_W-1:0];
                            if (op_next == OP_READ) begin
                                dout_oe_q <= 1'b1;
                                dout_q    <= 1'b0;
                            end else if (op_next == OP_CTRL && ctl_next == CTL_ENABLE) begin
                                wen_q <= 1'b1;
                            end else if (op_next == OP_CTRL && ctl_next == CTL_DISABLE) begin
                                wen_q <= 1'b0;
                            end
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                    ST_DATA: if (sk_rise_i) begin
                        data_q <= {data_q[DATA_W-2:0], di_i};
                        cnt_q  <= last_data ? '0 : cnt_q + CNT_W'(1);
                    end
                    ST_READ: if (sk_rise_i) begin
                        if (cnt_q == '0) begin
                            dout_q   <= rd_data_i[DATA_W-1];
                            out_sh_q <= {rd_data_i[DATA_W-2:0], 1'b0};
                        end else begin
                            dout_q   <= out_sh_q[DATA_W-1];
                            out_sh_q <= {out_sh_q[DATA_W-2:0], 1'b0};
                        end
                        if (last_data) begin
                            cnt_q  <= '0;
                            addr_q <= addr_q + ADDR_W'(1);
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                    ST_POLL: begin
                        dout_oe_q <= 1'b1;
                        dout_q    <= ~busy_i;
                        if (sk_rise_i && di_i && !busy_i) begin
                            dout_oe_q <= 1'b0;
                            dout_q    <= 1'b0;
                            stat_q    <= 1'b0;
                            cnt_q     <= '0;
                            cmd_q     <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_addr_o    = addr_q;
    assign prog_start_o = prog_start_q;
    assign prog_addr_o  = addr_q;
    assign prog_data_o  = data_q;
    assign dout_o       = dout_q;
    assign dout_oe_o    = dout_oe_q;

    // R9
    idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_i |=> !dout_oe_q);

    // R3
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ) |-> dout_oe_q);

    // R3
    dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dout_oe_q) && state_q == ST_READ) |-> !dout_q);

    // R7
    poll_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POLL && $past(state_q) == ST_POLL) |-> dout_oe_q);

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sclk_i,
    input  logic din_i,
    output logic dout_o,
    output logic dout_oe_o
);

    logic [2:0]        pins_s;
    logic              cs_s, sk_s, di_s, sk_prev_q, sk_rise;
    logic              busy, prog_start;
    logic [ADDR_W-1:0] rd_addr, prog_addr;
    logic [DATA_W-1:0] rd_data, prog_data;

    mw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_i, sclk_i, din_i}),
        .sync_o  (pins_s)
    );

    assign {cs_s, sk_s, di_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sk_prev_q <= 1'b0;
        else        sk_prev_q <= sk_s;
    end

    assign sk_rise = sk_s & ~sk_prev_q;

    mw_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_i         (cs_s),
        .sk_rise_i    (sk_rise),
        .di_i         (di_s),
        .busy_i       (busy),
        .rd_data_i    (rd_data),
        .rd_addr_o    (rd_addr),
        .prog_start_o (prog_start),
        .prog_addr_o  (prog_addr),
        .prog_data_o  (prog_data),
        .dout_o       (dout_o),
        .dout_oe_o    (dout_oe_o)
    );

    mw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (prog_start),
        .addr_i    (prog_addr),
        .data_i    (prog_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .busy_o    (busy)
    );

endmodule

// File: tb/mw_eeprom_test.sv
module mw_eeprom_test;

    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int DEPTH = 1 << AW;
    localparam int PROG  = 600;
    localparam int HALF  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic dout, oe;

    always #2.5 clk = ~clk;

    mw_eeprom #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PROG)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_i      (cs),
        .sclk_i    (sk),
        .din_i     (di),
        .dout_o    (dout),
        .dout_oe_o (oe)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [DW-1:0] model [DEPTH];
    bit wen_m = 1'b0;

    logic [DW-1:0] exp_q[$];
    logic [DW-1:0] obs_q[$];
    string         tag_q[$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic d, output logic q);
        di = d;
        wait_clk(HALF);
        sk = 1'b1;
        wait_clk(HALF);
        q = dout;
        sk = 1'b0;
    endtask

    task automatic send(input logic [31:0] v, input int n);
        logic q;
        for (int i = n - 1; i >= 0; i--) pulse(v[i], q);
    endtask

    task automatic cs_up;
        cs = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic cs_down;
        sk = 1'b0;
        di = 1'b0;
        cs = 1'b0;
        wait_clk(HALF);
    endtask

    // driver: clocks a read, queues expected and observed words
    task automatic read_body(input int a, input int nw, input string first_tag);
        logic q;
        logic [DW-1:0] word;
        send(32'(1), 1);
        send(32'(2'b10), 2);
        send(32'(a >> 1), AW - 1);
        pulse(a[0], q);
        check("R3 dummy zero", 32'(q), 32'(0));
        check("R3 data out driven", 32'(oe), 32'(1));
        for (int w = 0; w < nw; w++) begin
            int idx;
            idx = (a + w) % DEPTH;
            word = '0;
            for (int b = 0; b < DW; b++) begin
                pulse(1'b0, q);
                word = {word[DW-2:0], q};
            end
            exp_q.push_back(model[idx]);
            if (w == 0)        tag_q.push_back(first_tag);
            else if (idx == 0) tag_q.push_back("R5 wrap to zero");
            else               tag_q.push_back("R4 sequential word");
            obs_q.push_back(word);
        end
    endtask

    task automatic do_read(input int a, input int nw, input int lead, input string first_tag);
        cs_up;
        if (lead > 0) send(32'(0), lead);
        read_body(a, nw, first_tag);
        cs_down;
        check("R9 released after deselect", 32'(oe), 32'(0));
    endtask

    task automatic do_write(input int a, input logic [DW-1:0] d);
        cs_up;
        send(32'(1), 1);
        send(32'(2'b01), 2);
        send(32'(a), AW);
        send(32'(d), DW);
        cs_down;
        if (wen_m) model[a] = d;
    endtask

    task automatic wait_ready(input string tag);
        for (int t = 0; t < 4 * PROG && dout !== 1'b1; t++) wait_clk(1);
        check(tag, 32'({oe, dout}), 32'(2'b11));
    endtask

    task automatic write_wait(input int a, input logic [DW-1:0] d);
        do_write(a, d);
        cs_up;
        wait_ready("R7 ready after store");
        cs_down;
    endtask

    task automatic ctrl(input bit en);
        cs_up;
        send(32'(1), 1);
        send(32'(2'b00), 2);
        send(en ? 32'(6'b110000) : 32'(6'b000000), AW);
        cs_down;
        wen_m = en;
    endtask

    // monitor: compares each produced word with the expected one in order
    initial begin
        forever begin
            wait (obs_q.size() > 0);
            check(tag_q.pop_front(), 32'(obs_q.pop_front()), 32'(exp_q.pop_front()));
        end
    end

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        wait_clk(190000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        logic q;
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        wait_clk(5);
        check("R1 released in reset", 32'(oe), 32'(0));
        rst_n = 1'b1;
        wait_clk(5);
        check("R1 released after reset", 32'(oe), 32'(0));

        // R1: contents cleared
        do_read(10, 1, 0, "R1 word zero after reset");

        // R8: writes disabled from reset
        do_write(5, 16'hBEEF);
        cs_up;
        check("R8 no busy while disabled", 32'(oe), 32'(0));
        cs_down;
        do_read(5, 1, 0, "R8 disabled write ignored");

        // R8 enable, R6 store, R7 busy, R10 ignore while busy, R11 new command
        ctrl(1'b1);
        do_write(5, 16'hA5C3);
        cs_up;
        check("R7 busy shown", 32'({oe, dout}), 32'(2'b10));
        send(32'(1), 1);
        send(32'(2'b10), 2);
        send(32'(5), AW);
        check("R10 command ignored while busy", 32'({oe, dout}), 32'(2'b10));
        wait_ready("R7 ready shown");
        read_body(5, 1, "R11 read after ready");
        cs_down;

        // R6: direct overwrite
        write_wait(5, 16'h1234);
        do_read(5, 1, 0, "R6 overwrite without erase");

        // R4 and R5: sequential reads with wrap
        write_wait(62, 16'h6262);
        write_wait(63, 16'hF00D);
        write_wait(0, 16'h0A0A);
        write_wait(1, 16'h8001);
        do_read(62, 4, 0, "R3 first word");

        // R9: aborted write
        cs_up;
        send(32'(1), 1);
        send(32'(2'b01), 2);
        send(32'(7), AW);
        send(32'(8'hFF), 8);
        cs_down;
        check("R9 released on abort", 32'(oe), 32'(0));
        cs_up;
        check("R9 no store started", 32'(oe), 32'(0));
        cs_down;
        do_read(7, 1, 0, "R9 aborted write stored nothing");

        // R2: leading zeros before start bit
        do_read(63, 2, 3, "R2 start after leading zeros");

        // R8: disable again
        ctrl(1'b0);
        do_write(1, 16'hFFFF);
        do_read(1, 1, 0, "R8 write ignored after disable");

        pulse(1'b0, q);
        wait_clk(20);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule